// File: doc/BRIEF.md
# Single-Buffer Serial Channel Status and Data Registers

This block holds the software-visible state of one asynchronous serial channel that has no FIFO: one transmit holding register, one receive holding register, an 8-bit control register and an 8-bit status register. A bus master reaches them through a small register port. The block connects to an external bit serializer through a request handshake, and to an external deserializer that delivers whole received bytes. Bit timing, baud generation and interrupt routing live outside the block.

The status flags follow a read-then-clear protocol. A flag can only be cleared by a status write that carries 0 in its position, and only if software read that flag as 1 since the previous status write. Written 1s never set a flag. The transmit-end flag never stands without the transmit-empty flag. While the transmitter is disabled, neither of those two flags can be cleared. A single interrupt output combines the transmit-empty and receive-full conditions with their enables.

Top module: `sbuf_serial_status`

## Requirements
- R1: After reset the status register reads 0x84 (transmit-empty and transmit-end set), the control register reads 0x00, the transmit-data register reads 0xFF, the receive-data register reads 0x00, and irq and tx_req are 0.
- R2: The register select decodes 0 as control, 1 as status, 2 as transmit data and 3 as receive data. Control bits are: 7 transmit-interrupt enable, 6 receive-interrupt enable, 5 transmitter enable, 4 receiver enable. Status bits are: 7 transmit-empty, 6 receive-full, 5 overrun, 4 framing error, 3 parity error, 2 transmit-end, 1 multiprocessor bit, 0 multiprocessor transfer bit. Control and transmit data read back what was written.
- R3: A status write clears a flag in bits 7..2 only when the written bit is 0 and the flag was read as 1 since the last status write. A flag that was not read that way keeps its value, and a written 1 never sets a flag.
- R4: Each status write ANDs the remembered read-as-1 bits with the written value, so a flag written 1 stays clearable without a new read, and a flag written 0 needs a fresh read.
- R5: Status bit 0 takes the written value on every status write. Status bit 1 always reads 0.
- R6: While the transmitter enable is 0, a status write cannot clear transmit-empty or transmit-end.
- R7: If transmit-empty is 0 after a status write, transmit-end is also 0. A write to the transmit-data register clears transmit-end. Transmit-end is never 1 while transmit-empty is 0.
- R8: When transmit-empty is 0 and tx_busy is 0, tx_req is 1 for exactly one cycle with tx_data equal to the transmit-data register, and transmit-empty is set at the same edge. tx_done sets transmit-end when transmit-empty is 1.
- R9: With the receiver enabled, a byte on rx_valid is stored and sets receive-full. If receive-full is already set, the byte is dropped and overrun is set. With the receiver disabled, rx_valid has no effect. Reading the receive-data register clears receive-full.
- R10: A control write with the receiver enable bit 0 sets transmit-empty.
- R11: irq equals (transmit-interrupt enable AND transmit-empty) OR (receive-interrupt enable AND receive-full).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on status and receive data) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the selected register, combinational |
| tx_req | output | 1 | One-cycle request to the serializer |
| tx_data | output | DW | Byte handed over with tx_req |
| tx_busy | input | 1 | Serializer cannot take a byte |
| tx_done | input | 1 | Serializer finished a frame |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_data | input | DW | Received byte |
| irq | output | 1 | Combined interrupt |

## Verification
The clear protocol is swept over all 256 written values, with the transmitter enabled and disabled. Each value is tried once after a status read and once without one, starting from a state where transmit-empty, receive-full, overrun and transmit-end are set. The read/no-read pair separates the remembered-read gating from a plain write-0-clears rule. The two transmitter-enable settings separate the forced retention of the transmit flags from the normal clear. Directed sequences cover the held serializer handshake and its release, a second clear without a re-read, overrun data retention, a disabled receiver, a control write that drops the receiver enable, and each interrupt enable alone.

// File: rtl/sbuf_serial_pkg.sv
package sbuf_serial_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_TXD  = 2'd2,
    SEL_RXD  = 2'd3
  } reg_sel_e;

  localparam int unsigned STAT_W = 8;

  // status bit positions
  localparam int unsigned ST_TDRE = 7;
  localparam int unsigned ST_RDRF = 6;
  localparam int unsigned ST_ORER = 5;
  localparam int unsigned ST_TEND = 2;
  localparam int unsigned ST_MPB  = 1;
  localparam int unsigned ST_MPBT = 0;
  localparam int unsigned ST_FLAG_LO = 2;

  // control bit positions
  localparam int unsigned CT_TIE = 7;
  localparam int unsigned CT_RIE = 6;
  localparam int unsigned CT_TE  = 5;
  localparam int unsigned CT_RE  = 4;

  localparam logic [STAT_W-1:0] STAT_RESET = 8'h84;

  // value a status write is taken as, after the transmitter-off override
  function automatic logic [STAT_W-1:0] effective_wval(
    input logic [STAT_W-1:0] wval,
    input logic              te
  );
    logic [STAT_W-1:0] r;
    r = wval;
    if (!te) begin
      r[ST_TDRE] = 1'b1;
      r[ST_TEND] = 1'b1;
    end
    return r;
  endfunction

  // flag update caused by a status write alone
  function automatic logic [STAT_W-1:0] status_after_write(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] rmask,
    input logic [STAT_W-1:0] wval,
    input logic              te
  );
    logic [STAT_W-1:0] ev;
    logic [STAT_W-1:0] r;
    ev = effective_wval(wval, te);
    r  = cur;
    for (int b = ST_FLAG_LO; b < STAT_W; b++) begin
      r[b] = cur[b] & (~rmask[b] | ev[b]);
    end
    r[ST_MPB]  = cur[ST_MPB];
    r[ST_MPBT] = wval[ST_MPBT];
    if (!r[ST_TDRE]) r[ST_TEND] = 1'b0;
    return r;
  endfunction

  function automatic logic irq_combine(
    input logic [STAT_W-1:0] ctrl,
    input logic [STAT_W-1:0] stat
  );
    return (ctrl[CT_TIE] & stat[ST_TDRE]) | (ctrl[CT_RIE] & stat[ST_RDRF]);
  endfunction

endpackage

// File: rtl/sbuf_tx_path.sv
module sbuf_tx_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_txd,
  input  logic [DW-1:0] wval,
  input  logic          tdre,
  input  logic          tx_busy,
  output logic          launch,
  output logic [DW-1:0] tdr,
  output logic          tx_req,
  output logic [DW-1:0] tx_data
);

  localparam logic [DW-1:0] TDR_RESET = '1;

  logic [DW-1:0] tdr_q;
  logic [DW-1:0] txd_q;
  logic          req_q;

  // a byte is pending while the empty flag is low
  assign launch = ~tdre & ~tx_busy & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr_q <= TDR_RESET;
      txd_q <= '0;
      req_q <= 1'b0;
    end else begin
      if (wr_txd) tdr_q <= wval;
      if (launch) txd_q <= tdr_q;
      req_q <= launch;
    end
  end

  assign tdr     = tdr_q;
  assign tx_req  = req_q;
  assign tx_data = txd_q;

  assert_req_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  assert_req_carries_tdr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !wr_txd) |=> (tx_req && tx_data == tdr_q));

endmodule

// File: rtl/sbuf_rx_path.sv
module sbuf_rx_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_en,
  input  logic          rdrf,
  output logic          accept,
  output logic          overrun,
  output logic [DW-1:0] rdr
);

  logic [DW-1:0] rdr_q;
  logic          take;

  assign take    = rx_valid & rx_en;
  assign accept  = take & ~rdrf;
  assign overrun = take & rdrf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdr_q <= '0;
    else if (accept) rdr_q <= rx_data;
  end

  assign rdr = rdr_q;

  assert_overrun_drops_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> $stable(rdr_q));

  assert_rx_off_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_en) |=> $stable(rdr_q));

endmodule

// File: rtl/sbuf_status_reg.sv
module sbuf_status_reg
  import sbuf_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stat,
  input  logic              wr_stat,
  input  logic              wr_txd,
  input  logic              rd_rxd,
  input  logic              rx_off_write,
  input  logic [STAT_W-1:0] wval,
  input  logic              te,
  input  logic              launch,
  input  logic              tx_done,
  input  logic              rx_accept,
  input  logic              rx_overrun,
  output logic [STAT_W-1:0] status
);

  logic [STAT_W-1:0] stat_q, stat_d;
  logic [STAT_W-1:0] rmask_q, rmask_d;
  logic [STAT_W-1:0] after_bus;
  logic              hw_set;

  always_comb begin
    after_bus = stat_q;
    if (wr_stat) after_bus = status_after_write(stat_q, rmask_q, wval, te);

    stat_d = after_bus;
    if (wr_txd)       stat_d[ST_TEND] = 1'b0;
    if (rx_off_write) stat_d[ST_TDRE] = 1'b1;
    if (rd_rxd)       stat_d[ST_RDRF] = 1'b0;
    if (launch)       stat_d[ST_TDRE] = 1'b1;
    if (tx_done && after_bus[ST_TDRE]) stat_d[ST_TEND] = 1'b1;
    if (rx_accept)    stat_d[ST_RDRF] = 1'b1;
    if (rx_overrun)   stat_d[ST_ORER] = 1'b1;
  end

  always_comb begin
    rmask_d = rmask_q;
    if (rd_stat)      rmask_d = rmask_q | stat_q;
    else if (wr_stat) rmask_d = rmask_q & effective_wval(wval, te);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= STAT_RESET;
      rmask_q <= '0;
    end else begin
      stat_q  <= stat_d;
      rmask_q <= rmask_d;
    end
  end

  assign status = stat_q;
  assign hw_set = launch | tx_done | rx_accept | rx_overrun;

  assert_write_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !hw_set) |=>
      ((stat_q[STAT_W-1:ST_FLAG_LO] & ~$past(stat_q[STAT_W-1:ST_FLAG_LO])) == '0));

  assert_unread_flag_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !rmask_q[ST_RDRF] && stat_q[ST_RDRF]) |=> stat_q[ST_RDRF]);

  assert_tend_needs_tdre_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[ST_TEND] |-> stat_q[ST_TDRE]);

  assert_tx_off_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !te && stat_q[ST_TDRE]) |=> stat_q[ST_TDRE]);

  assert_launch_sets_tdre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> stat_q[ST_TDRE]);

  assert_mpb_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[ST_MPB]);

endmodule

// File: rtl/sbuf_serial_status.sv
module sbuf_serial_status
  import sbuf_serial_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_req,
  output logic [DW-1:0] tx_data,
  input  logic          tx_busy,
  input  logic          tx_done,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          irq
);

  reg_sel_e          sel;
  logic              rd_ok;
  logic              wr_ctrl, wr_stat, wr_txd;
  logic              rd_stat, rd_rxd;
  logic              rx_off_write;
  logic [STAT_W-1:0] ctrl_q;
  logic [STAT_W-1:0] wval8;
  logic [STAT_W-1:0] status;
  logic [DW-1:0]     tdr, rdr;
  logic              launch, rx_accept, rx_overrun;

  assign sel     = reg_sel_e'(bus_sel);
  assign rd_ok   = bus_rd & ~bus_wr;
  assign wval8   = bus_wdata[STAT_W-1:0];
  assign wr_ctrl = bus_wr & (sel == SEL_CTRL);
  assign wr_stat = bus_wr & (sel == SEL_STAT);
  assign wr_txd  = bus_wr & (sel == SEL_TXD);
  assign rd_stat = rd_ok  & (sel == SEL_STAT);
  assign rd_rxd  = rd_ok  & (sel == SEL_RXD);
  assign rx_off_write = wr_ctrl & ~wval8[CT_RE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wval8;
  end

  sbuf_status_reg u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_stat      (rd_stat),
    .wr_stat      (wr_stat),
    .wr_txd       (wr_txd),
    .rd_rxd       (rd_rxd),
    .rx_off_write (rx_off_write),
    .wval         (wval8),
    .te           (ctrl_q[CT_TE]),
    .launch       (launch),
    .tx_done      (tx_done),
    .rx_accept    (rx_accept),
    .rx_overrun   (rx_overrun),
    .status       (status)
  );

  sbuf_tx_path #(.DW(DW)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_txd  (wr_txd),
    .wval    (bus_wdata),
    .tdre    (status[ST_TDRE]),
    .tx_busy (tx_busy),
    .launch  (launch),
    .tdr     (tdr),
    .tx_req  (tx_req),
    .tx_data (tx_data)
  );

  sbuf_rx_path #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_en    (ctrl_q[CT_RE]),
    .rdrf     (status[ST_RDRF]),
    .accept   (rx_accept),
    .overrun  (rx_overrun),
    .rdr      (rdr)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: bus_rdata = DW'(ctrl_q);
      SEL_STAT: bus_rdata = DW'(status);
      SEL_TXD:  bus_rdata = tdr;
      default:  bus_rdata = rdr;
    endcase
  end

  assign irq = irq_combine(ctrl_q, status);

  assert_rx_off_sets_tdre_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_off_write |=> status[ST_TDRE]);

  assert_irq_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[ST_TDRE] | status[ST_RDRF]));

  assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == $past(wval8)));

endmodule

// File: tb/test_sbuf_serial_status.sv
`timescale 1ns/1ps
module test_sbuf_serial_status;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_sel = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          tx_req;
  logic [DW-1:0] tx_data;
  logic          tx_busy = 1'b0;
  logic          tx_done = 1'b0;
  logic          rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          irq;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sbuf_serial_status #(.DW(DW)) i_sbuf_serial_status (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_req(tx_req), .tx_data(tx_data),
    .tx_busy(tx_busy), .tx_done(tx_done), .rx_valid(rx_valid), .rx_data(rx_data),
    .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; tx_busy = 0; tx_done = 0; rx_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    bus_sel = s; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // expected status after one status write, from the clear rules
  function automatic logic [7:0] model_write(input logic [7:0] pre, input bit was_read,
                                             input logic [7:0] v, input bit te);
    logic [7:0] r;
    for (int b = 2; b < 8; b++) begin
      bit protect;
      protect = !te && (b == 7 || b == 2);
      r[b] = pre[b] && (!was_read || v[b] || protect);
    end
    r[1] = 1'b0;
    r[0] = v[0];
    if (!r[7]) r[2] = 1'b0;
    return r;
  endfunction

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;

    // R1 reset values
    do_reset();
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 tx_req", {7'b0, tx_req}, 8'h00);
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h84);
    rd(2'd2, v); check("R1 txd", v, 8'hFF);
    rd(2'd3, v); check("R1 rxd", v, 8'h00);

    // R2 readback of control and transmit data
    wr(2'd0, 8'h30); rd(2'd0, v); check("R2 ctrl readback", v, 8'h30);
    tx_busy = 1'b1;
    wr(2'd2, 8'h5A); rd(2'd2, v); check("R2 txd readback", v, 8'h5A);

    // R3/R4/R5/R6 sweep of the write value, transmitter on/off, with/without read
    for (int te = 0; te < 2; te++) begin
      for (int mode = 0; mode < 2; mode++) begin
        for (int w = 0; w < 256; w++) begin
          logic [7:0] got;
          do_reset();
          tx_busy = 1'b1;
          wr(2'd0, (te != 0) ? 8'h30 : 8'h10);
          rx_byte(8'h11);
          rx_byte(8'h22);
          if (mode != 0) begin
            rd(2'd1, got);
            check("R9 pre-sweep flags", got, 8'hE4);
          end
          wr(2'd1, w[7:0]);
          rd(2'd1, got);
          check((te != 0) ? "R3 R4 R5 sweep" : "R6 sweep", got,
                model_write(8'hE4, mode != 0, w[7:0], te != 0));
        end
      end
    end

    // R7 R8 transmit handshake held by the serializer, then released
    do_reset();
    wr(2'd0, 8'h30);
    tx_busy = 1'b1;
    wr(2'd2, 8'hA5);
    rd(2'd1, v); check("R7 txd write clears TEND", v, 8'h80);
    wr(2'd1, 8'h7F);
    rd(2'd1, v); check("R7 TEND low with TDRE", v, 8'h01);
    check("R8 no request while busy", {7'b0, tx_req}, 8'h00);
    @(negedge clk); tx_busy = 1'b0;
    @(negedge clk);
    check("R8 request raised", {7'b0, tx_req}, 8'h01);
    check("R8 request data", tx_data, 8'hA5);
    tx_busy = 1'b1;
    @(negedge clk);
    check("R8 request one cycle", {7'b0, tx_req}, 8'h00);
    rd(2'd1, v); check("R8 TDRE set by launch", v, 8'h81);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    rd(2'd1, v); check("R8 tx_done sets TEND", v, 8'h85);
    tx_busy = 1'b0;

    // R4 mask kept by written 1, clear later without re-read
    do_reset();
    wr(2'd0, 8'h30);
    tx_busy = 1'b1;
    rd(2'd1, v);
    wr(2'd1, 8'hFB);
    wr(2'd1, 8'h7E);
    rd(2'd1, v); check("R4 clear without re-read", v, 8'h00);

    // R4 R3 mask dropped by written 0; new flag needs a read
    do_reset();
    wr(2'd0, 8'h30);
    tx_busy = 1'b1;
    rd(2'd1, v);
    wr(2'd1, 8'h7B);
    rx_byte(8'h44);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R4 unread RDRF kept", v, 8'h40);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R3 read then write 0 clears", v, 8'h00);

    // R9 receive path
    do_reset();
    rx_byte(8'h3C);
    rd(2'd1, v); check("R9 rx off status", v, 8'h84);
    rd(2'd3, v); check("R9 rx off data", v, 8'h00);
    wr(2'd0, 8'h10);
    rx_byte(8'h3C);
    rx_byte(8'h99);
    rd(2'd1, v); check("R9 overrun flags", v, 8'hE4);
    rd(2'd3, v); check("R9 first byte kept", v, 8'h3C);
    rd(2'd1, v); check("R9 rxd read clears RDRF", v, 8'hA4);

    // R10 receiver-off control write forces TDRE
    do_reset();
    wr(2'd0, 8'h30);
    tx_busy = 1'b1;
    rd(2'd1, v);
    wr(2'd1, 8'h7F);
    rd(2'd1, v); check("R10 TDRE cleared first", v, 8'h01);
    wr(2'd0, 8'h20);
    rd(2'd1, v); check("R10 TDRE forced", v, 8'h81);

    // R11 interrupt combination
    do_reset();
    wr(2'd0, 8'h80);
    check("R11 TIE with TDRE", {7'b0, irq}, 8'h01);
    wr(2'd0, 8'h50);
    check("R11 RIE without RDRF", {7'b0, irq}, 8'h00);
    rx_byte(8'h12);
    check("R11 RIE with RDRF", {7'b0, irq}, 8'h01);
    rd(2'd3, v);
    check("R11 cleared by rxd read", {7'b0, irq}, 8'h00);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule